// File: doc/BRIEF.md
# Manual Reset Pushbutton Debouncer

This block cleans up an active-low reset request input that may come from a mechanical pushbutton or from external logic. The input is brought into the clock domain through a chain of synchronising flops. A run of low samples is then timed in units of one millisecond. Only a press that lasts for the acceptance threshold turns into a reset request. The acceptance threshold is set by the `ACCEPT_MS` parameter, which defaults to 10 ms. The threshold may be set anywhere from 2 ms to 20 ms. With any setting in that range, a glitch shorter than 1 ms is always rejected and a press of 20 ms or longer is always accepted.

The output is a level. It rises once the press has been qualified and stays high while the button is held. It drops only after the input has been back high for the same threshold, so contact bounce on release cannot restart a request. A separate stretcher further downstream applies the reset hold time. The millisecond timebase is derived from the clock by the `CYCLES_PER_MS` parameter. The timebase restarts whenever the synchronised input changes level, so the filter counts exact sample runs. Each counted run is one stretch of consecutive clock samples at the same level.

Top module: `mreset_debounce`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `req_o` is 0. The synchroniser resets to the released (high) level.
- R2: A low run on `btn_ni` of fewer than ACCEPT_MS*CYCLES_PER_MS consecutive clock samples never raises `req_o`. This covers every pulse shorter than 1 ms.
- R3: A low run of exactly ACCEPT_MS*CYCLES_PER_MS samples raises `req_o`. Count the first rising edge that samples the input low as edge 1. Then `req_o` is high after edge ACCEPT_MS*CYCLES_PER_MS + SYNC_STAGES.
- R4: A low run of 20*CYCLES_PER_MS samples or more always raises `req_o`. Elaboration rejects any ACCEPT_MS outside 2..20, any SYNC_STAGES below 2 and any CYCLES_PER_MS below 1.
- R5: While `req_o` is high, it stays high as long as the input remains low. It also stays high through high runs shorter than ACCEPT_MS*CYCLES_PER_MS samples.
- R6: While `req_o` is high, a high run of ACCEPT_MS*CYCLES_PER_MS samples drops it. The latency is the same as in R3: low after edge ACCEPT_MS*CYCLES_PER_MS + SYNC_STAGES.
- R7: A single high sample (input 1 means released, which is also the idle state) restarts the low-run count from zero. Two sub-threshold low runs separated by one high sample do not raise `req_o`, even when their total exceeds the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | 1 | Asynchronous pushbutton or logic reset input, low = pressed |
| req_o | output | 1 | Qualified manual reset request level, high = request |

## Verification
The bench aims at the exact threshold edge. A press one sample short of the threshold must be dropped and a press of exactly the threshold must be taken. A filter that is off by one in either direction, or that counts from the raw pin instead of the synchronised copy, shows up as a wrong rise or fall cycle. Release bounce just under the threshold is applied while the request is held; a design that releases on the first high sample would drop the request there. Runs split by a single high sample catch a counter that does not clear, because that counter would fire on the summed time. Random bursts mixing short, near-threshold and long runs are compared cycle by cycle against a bench model.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

   // Hard limits on the acceptance threshold, in milliseconds
   localparam int unsigned REJECT_BELOW_MS = 1;
   localparam int unsigned ACCEPT_BY_MS    = 20;

   typedef enum logic {
      BTN_RELEASED = 1'b0,
      BTN_PRESSED  = 1'b1
   } btn_state_e;

   // Counter width able to hold values 0..max_val
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/mrd_sync.sv
module mrd_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= RESET_VAL;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[i] <= RESET_VAL;
               else         chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mrd_timebase.sv
module mrd_timebase #(
   parameter int unsigned CYCLES_PER_MS = 100000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);

   generate
      if (CYCLES_PER_MS == 1) begin : g_direct
         // Every running cycle is a full millisecond
         assign tick_o = run_i;
      end else begin : g_prescale
         localparam int unsigned PW = mrd_pkg::cnt_width(CYCLES_PER_MS - 1);
         localparam logic [PW-1:0] LAST = PW'(CYCLES_PER_MS - 1);

         logic [PW-1:0] pre_q;
         logic          at_last;

         assign at_last = (pre_q == LAST);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       pre_q <= '0;
            else if (!run_i)   pre_q <= '0;
            else if (at_last)  pre_q <= '0;
            else               pre_q <= pre_q + 1'b1;
         end

         assign tick_o = run_i && at_last;
      end
   endgenerate

endmodule

// File: rtl/mrd_qualifier.sv
module mrd_qualifier #(
   parameter int unsigned ACCEPT_MS = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic tick_i,
   output logic done_o
);

   localparam int unsigned MW = mrd_pkg::cnt_width(ACCEPT_MS - 1);
   localparam logic [MW-1:0] MS_LAST = MW'(ACCEPT_MS - 1);

   logic [MW-1:0] ms_q;
   logic          full;

   assign full = (ms_q == MS_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ms_q <= '0;
      else if (!run_i)    ms_q <= '0;
      else if (tick_i) begin
         if (full)        ms_q <= '0;
         else             ms_q <= ms_q + 1'b1;
      end
   end

   assign done_o = run_i && tick_i && full;

endmodule

// File: rtl/mreset_debounce.sv
module mreset_debounce #(
   parameter int unsigned CYCLES_PER_MS = 100000,
   parameter int unsigned ACCEPT_MS     = 10,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic btn_ni,
   output logic req_o
);

   import mrd_pkg::*;

   generate
      if (ACCEPT_MS < 2 || ACCEPT_MS > ACCEPT_BY_MS) begin : g_bad_accept
         $error("ACCEPT_MS must lie in 2..20");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CYCLES_PER_MS < REJECT_BELOW_MS) begin : g_bad_rate
         $error("CYCLES_PER_MS must be at least 1");
      end
   endgenerate

   logic       btn_sync_n;
   logic       opposite;
   logic       ms_tick;
   logic       flip;
   btn_state_e state_q;

   mrd_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (btn_ni),
      .q_o    (btn_sync_n)
   );

   // Count only while the synchronised level disagrees with the state
   always_comb begin
      unique case (state_q)
         BTN_RELEASED: opposite = ~btn_sync_n;
         BTN_PRESSED:  opposite =  btn_sync_n;
         default:      opposite = 1'b0;
      endcase
   end

   mrd_timebase #(
      .CYCLES_PER_MS (CYCLES_PER_MS)
   ) u_timebase (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (opposite),
      .tick_o (ms_tick)
   );

   mrd_qualifier #(
      .ACCEPT_MS (ACCEPT_MS)
   ) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (opposite),
      .tick_i (ms_tick),
      .done_o (flip)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   state_q <= BTN_RELEASED;
      else if (flip) state_q <= (state_q == BTN_PRESSED) ? BTN_RELEASED : BTN_PRESSED;
   end

   assign req_o = (state_q == BTN_PRESSED);

endmodule

// File: rtl/mreset_debounce_chk.sv
module mreset_debounce_chk #(
   parameter int unsigned CYCLES_PER_MS = 100000,
   parameter int unsigned ACCEPT_MS     = 10,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input logic clk_i,
   input logic rst_ni,
   input logic btn_ni,
   input logic req_o
);

   localparam int unsigned RUN_LEN = ACCEPT_MS * CYCLES_PER_MS;
   localparam int unsigned LIM     = RUN_LEN + SYNC_STAGES;
   localparam int unsigned CW      = mrd_pkg::cnt_width(LIM);
   localparam logic [CW-1:0] LIM_V  = CW'(LIM);
   localparam logic [CW-1:0] SYNC_V = CW'(SYNC_STAGES);

   logic [CW-1:0] lo_run_q;
   logic [CW-1:0] hi_run_q;

   // Saturating run lengths of the raw pin
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_run_q <= '0;
         hi_run_q <= '0;
      end else if (!btn_ni) begin
         hi_run_q <= '0;
         if (lo_run_q != LIM_V) lo_run_q <= lo_run_q + 1'b1;
      end else begin
         lo_run_q <= '0;
         if (hi_run_q != LIM_V) hi_run_q <= hi_run_q + 1'b1;
      end
   end

   always @(posedge clk_i) begin
      if (!rst_ni) AST_RESET_IDLE: assert (!req_o); // R1
   end

   AST_REQ_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$isunknown(req_o)); // R1

   AST_LONG_PRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lo_run_q == LIM_V) |-> req_o); // R4

   AST_HOLD_PRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && lo_run_q >= SYNC_V) |=> req_o); // R5

   AST_LONG_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hi_run_q == LIM_V) |-> !req_o); // R6

   AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_o && hi_run_q >= SYNC_V) |=> !req_o); // R7

endmodule

bind mreset_debounce mreset_debounce_chk #(
   .CYCLES_PER_MS (CYCLES_PER_MS),
   .ACCEPT_MS     (ACCEPT_MS),
   .SYNC_STAGES   (SYNC_STAGES)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .btn_ni (btn_ni),
   .req_o  (req_o)
);

// File: tb/mreset_debounce_test.sv
module mreset_debounce_test;

   localparam int P  = 8;
   localparam int A  = 10;
   localparam int S  = 2;
   localparam int AP = A * P;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_n = 1'b1;
   logic req;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";
   logic exp_req = 1'b0;
   int   run = 0;
   logic hist [0:S-1];
   bit   done = 1'b0;

   always #4 clk = ~clk;

   mreset_debounce #(
      .CYCLES_PER_MS (P),
      .ACCEPT_MS     (A),
      .SYNC_STAGES   (S)
   ) uut (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .btn_ni (btn_n),
      .req_o  (req)
   );

   // Reference model: a level toggles after AP consecutive opposite samples,
   // seen through an S-sample input delay
   always @(posedge clk) begin
      logic d, opp;
      if (!rst_n) begin
         exp_req = 1'b0;
         run = 0;
         for (int k = 0; k < S; k++) hist[k] = 1'b1;
      end else begin
         d = hist[S-1];
         opp = exp_req ? d : !d;
         if (opp) begin
            run++;
            if (run == AP) begin
               exp_req = !exp_req;
               run = 0;
            end
         end else begin
            run = 0;
         end
         for (int k = S-1; k > 0; k--) hist[k] = hist[k-1];
         hist[0] = btn_n;
      end
   end

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: req_o=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) check(cur_tag, req, exp_req);
   end

   task automatic drive(input logic v, input int n);
      @(negedge clk) btn_n = v;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic measure(input logic v, input logic target, input string tag);
      int n = 0;
      @(negedge clk) btn_n = v;
      while (req !== target && n < 4 * AP) begin
         @(negedge clk);
         n++;
      end
      checks++;
      if (n != AP + S) begin
         errors++;
         $display("FAIL %s: latency %0d expected %0d", tag, n, AP + S);
      end
   endtask

   initial begin
      void'($urandom(32'd1832));
      repeat (3) @(negedge clk);
      check("R1", req, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      check("R1", req, 1'b0);
      drive(1'b1, 10);

      cur_tag = "R2";
      drive(1'b0, P - 1); drive(1'b1, 3 * AP);
      check("R2", req, 1'b0);
      drive(1'b0, AP - 1); drive(1'b1, 3 * AP);
      check("R2", req, 1'b0);

      cur_tag = "R7";
      drive(1'b0, AP - 1); drive(1'b1, 1); drive(1'b0, AP - 1); drive(1'b1, 3 * AP);
      check("R7", req, 1'b0);

      cur_tag = "R3";
      measure(1'b0, 1'b1, "R3");
      check("R3", req, 1'b1);

      cur_tag = "R5";
      drive(1'b0, 50);
      drive(1'b1, AP - 1); drive(1'b0, 20);
      check("R5", req, 1'b1);
      drive(1'b1, 3); drive(1'b0, 20);
      check("R5", req, 1'b1);

      cur_tag = "R6";
      measure(1'b1, 1'b0, "R6");
      check("R6", req, 1'b0);

      cur_tag = "R4";
      drive(1'b1, 40);
      drive(1'b0, 20 * P);
      check("R4", req, 1'b1);
      drive(1'b1, 3 * AP);
      check("R6", req, 1'b0);

      cur_tag = "R1";
      @(negedge clk) rst_n = 1'b0;
      btn_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", req, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      check("R1", req, 1'b0);
      drive(1'b0, 5); drive(1'b1, 3 * AP);

      cur_tag = "R2/R3 random";
      for (int i = 0; i < 400; i++) begin
         int cls = int'($urandom_range(0, 3));
         int len;
         case (cls)
            0: len = int'($urandom_range(1, P - 1));
            1: len = int'($urandom_range(P, AP - 1));
            2: len = int'($urandom_range(AP - 2, AP + 2));
            default: len = int'($urandom_range(AP, 3 * AP));
         endcase
         drive(btn_n ? 1'b0 : 1'b1, len);
      end
      drive(1'b1, 3 * AP);
      check("R6", req, 1'b0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule